// File: doc/BRIEF.md
# Reset Vector Fetch Controller

This block takes a small CPU from an unknown state to a known one. A synchronous active-low reset places it in a hold state. While it is held there, the condition code register takes a fixed value: the stop-disable bit and both interrupt-mask bits are set, and every arithmetic flag is cleared. The program counter is zeroed, and the memory read port already addresses the first byte of the reset vector.

After the reset input goes high, the controller reads the two vector bytes at the top of the address space. The high byte is at the lower of the two addresses and the low byte is at the top address. The memory returns read data one cycle after it sees an address. The controller assembles the two bytes into the program counter and then raises `run`, which hands control to the normal fetch sequencer. From then on it holds the program counter and the flags until the next reset. The stack pointer and the other CPU registers are not handled here.

Top module: `reset_vector_fetch`

## Requirements
- R1: In the cycle after a clock edge with `rst_n` low, `run` is 0, `pc` is 0x0000, `ccr` is 0xD0 and `mem_addr` is 0xFFFE.
- R2: `ccr` bit positions are S=7, X=6, H=5, I=4, N=3, Z=2, V=1, C=0. S, X and I are set and H, N, Z, V, C are cleared, so `ccr` reads 0xD0 at every cycle after the first reset.
- R3: In the first cycle after the first edge with `rst_n` high, `mem_addr` is 0xFFFF.
- R4: At the edge that ends the 0xFFFF cycle, `pc[15:8]` takes the byte the memory returns that cycle, which is the byte stored at 0xFFFE. At the next edge `pc[7:0]` takes the byte stored at 0xFFFF.
- R5: `run` rises exactly three clock edges after the first edge with `rst_n` high. It then stays high until `rst_n` is low at an edge.
- R6: With 0x30 stored at 0xFFFE and 0x00 at 0xFFFF, `pc` reads 0x3000 when `run` rises.
- R7: While `run` is high, `pc` does not change and `mem_addr` equals `pc`.
- R8: If `rst_n` goes low at any point, including part-way through the vector read or while running, the whole sequence starts again. Bytes read before that reset are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Read address presented to memory |
| mem_rdata | input | 8 | Byte returned for the address of the previous cycle |
| pc | output | 16 | Program counter |
| ccr | output | 8 | Condition code register |
| run | output | 1 | High once the program counter holds the vector |

## Verification
The hardest case to reach is a reset that lands part-way through the vector read. At that moment one byte of the program counter has been captured and the other has not. In the next sequence, a late or early capture would pick up a stale byte. The stimulus releases reset and then reasserts it one cycle later and again two cycles later, changing the stored vector while reset is held each time. A cycle-level model then predicts `pc`, `mem_addr` and `run` on every clock, and any byte left over from the cut-short read shows up as a mismatch.

// File: rtl/rvf_pkg.sv
// Shared definitions for the reset vector fetch controller.
// Holds the sequencer state encoding and the condition code bit positions.
// The bit positions are fixed because the execution unit decodes them.
package rvf_pkg;

    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_VEC_HI  = 2'd1,
        ST_VEC_LO  = 2'd2,
        ST_ACTIVE  = 2'd3
    } rvf_state_e;

    localparam int CCR_W     = 8;
    localparam int CCR_STOP  = 7;
    localparam int CCR_XMASK = 6;
    localparam int CCR_IMASK = 4;

    // Value loaded into the flags on reset: control bits set, arithmetic bits clear.
    function automatic logic [CCR_W-1:0] ccr_reset_value();
        logic [CCR_W-1:0] v;
        v = '0;
        v[CCR_STOP]  = 1'b1;
        v[CCR_XMASK] = 1'b1;
        v[CCR_IMASK] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rvf_seq.sv
// State sequencer of the reset vector fetch.
// Walks from the hold state through the two vector byte reads to the active state.
// Assumes a synchronous, active-low reset. Once it reaches the active state it
// stays there until the next reset.
module rvf_seq
    import rvf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    output rvf_state_e state
);

    rvf_state_e state_nx;

    // Next-state selection: advance one step per cycle until active.
    always_comb begin
        case (state)
            ST_HOLD:   state_nx = ST_VEC_HI;
            ST_VEC_HI: state_nx = ST_VEC_LO;
            ST_VEC_LO: state_nx = ST_ACTIVE;
            default:   state_nx = ST_ACTIVE;
        endcase
    end

    // State register with synchronous reset to the hold state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

endmodule

// File: rtl/rvf_pc_load.sv
// Program counter loader.
// Captures the byte lanes of the reset vector, one lane per read state.
// Assumes the memory returns data one cycle after the address. The byte for
// the address presented in state k is therefore on rdata during state k+1.
// The most significant lane is captured first.
module rvf_pc_load
    import rvf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  rvf_state_e             state,
    input  logic [ADDR_W/2-1:0]    rdata,
    output logic [ADDR_W-1:0]      pc
);

    localparam int BYTE_W = ADDR_W / 2;
    localparam int LANES  = 2;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam rvf_state_e CAP_ST = (g == LANES - 1) ? ST_VEC_HI : ST_VEC_LO;

        // Lane register: cleared on reset, loaded once in its capture state.
        always_ff @(posedge clk) begin
            if (!rst_n)               pc[g*BYTE_W +: BYTE_W] <= '0;
            else if (state == CAP_ST) pc[g*BYTE_W +: BYTE_W] <= rdata;
        end
    end

endmodule

// File: rtl/rvf_ccr_init.sv
// Condition code register initialiser.
// Forces the stop-disable and both interrupt-mask bits high and the arithmetic
// flags low on reset. Outside reset it holds its value, since instruction
// execution is handled elsewhere.
module rvf_ccr_init
    import rvf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    output logic [CCR_W-1:0] ccr
);

    // Flags register: load the reset pattern, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) ccr <= ccr_reset_value();
        else        ccr <= ccr;
    end

endmodule

// File: rtl/reset_vector_fetch.sv
// Reset vector fetch controller, top level.
// Puts the CPU in a known state after an active-low synchronous reset and
// reads the big-endian reset vector from the two top addresses into the PC.
// It then raises run. Assumes a memory with one cycle of read latency and
// ADDR_W equal to twice the byte width.
module reset_vector_fetch
    import rvf_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [ADDR_W/2-1:0] mem_rdata,
    output logic [ADDR_W-1:0]   pc,
    output logic [CCR_W-1:0]    ccr,
    output logic                run
);

    localparam logic [ADDR_W-1:0] VEC_LO_ADDR = '1;
    localparam logic [ADDR_W-1:0] VEC_HI_ADDR = {{(ADDR_W-1){1'b1}}, 1'b0};

    rvf_state_e state;

    rvf_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state)
    );

    rvf_pc_load #(.ADDR_W(ADDR_W)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .state (state),
        .rdata (mem_rdata),
        .pc    (pc)
    );

    rvf_ccr_init u_ccr (
        .clk   (clk),
        .rst_n (rst_n),
        .ccr   (ccr)
    );

    // Address select: high vector byte in hold, low byte next, then the PC.
    always_comb begin
        case (state)
            ST_HOLD:   mem_addr = VEC_HI_ADDR;
            ST_VEC_HI: mem_addr = VEC_LO_ADDR;
            default:   mem_addr = pc;
        endcase
    end

    // Run flag: control passes to the fetch sequencer only in the active state.
    always_comb run = (state == ST_ACTIVE);

endmodule

// File: rtl/reset_vector_fetch_chk.sv
// Assertion checker for the reset vector fetch controller, bound to the top.
// Watches only the ports. Properties are enabled once a reset has been seen.
module reset_vector_fetch_chk #(
    parameter int ADDR_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   mem_addr,
    input logic [ADDR_W/2-1:0] mem_rdata,
    input logic [ADDR_W-1:0]   pc,
    input logic [7:0]          ccr,
    input logic                run
);

    localparam logic [ADDR_W-1:0] LO_A = '1;
    localparam logic [ADDR_W-1:0] HI_A = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic seen = 1'b0;

    // Note that a reset edge has occurred, after which all outputs are defined.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b1;
    end

    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(rst_n) |-> (!run && pc == '0 && mem_addr == HI_A)); // R1

    AST_CCR_PATTERN: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        ccr == 8'hD0); // R2

    AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(rst_n) |=> mem_addr == LO_A); // R3

    AST_PC_ASSEMBLY: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(run) |-> pc == {$past(mem_rdata, 2), $past(mem_rdata, 1)}); // R4

    AST_RUN_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $rose(run) |-> $past(mem_addr, 2) == LO_A); // R5

    AST_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        $past(run) |-> run); // R5

    AST_PC_STABLE: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (run && $past(run)) |-> $stable(pc)); // R7

    AST_ADDR_IS_PC: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        run |-> mem_addr == pc); // R7

endmodule

bind reset_vector_fetch reset_vector_fetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .pc        (pc),
    .ccr       (ccr),
    .run       (run)
);

// File: tb/reset_vector_fetch_tb_top.sv
// Bench for the reset vector fetch controller. A cycle-level model in the bench
// is compared with the ports on every falling edge, and scenario checks are
// added on top.
module reset_vector_fetch_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] pc;
    logic [7:0]  ccr;
    logic        run;

    logic [7:0]  vec_hi = 8'h30;
    logic [7:0]  vec_lo = 8'h00;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    always #4 clk = ~clk; // 125 MHz

    reset_vector_fetch dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .pc        (pc),
        .ccr       (ccr),
        .run       (run)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        if (a == 16'hFFFE)      return vec_hi;
        else if (a == 16'hFFFF) return vec_lo;
        else                    return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // Memory with one cycle of read latency.
    always @(posedge clk) mem_rdata <= mem_byte(mem_addr);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model: phase counts edges since release, capped at the run phase.
    int          ph = 0;
    logic [15:0] epc = 16'h0;
    bit          started = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            started <= 1;
            ph      <= 0;
            epc     <= 16'h0;
        end else begin
            if (ph == 1) epc[15:8] <= vec_hi;
            if (ph == 2) epc[7:0]  <= vec_lo;
            if (ph < 3)  ph <= ph + 1;
        end
    end

    // Per-cycle comparison of every output against the model.
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R5 run", run, ph == 3);
            chk("R2 ccr", ccr, 8'hD0);
            chk("R4 pc", pc, epc);
            chk("R3/R7 mem_addr", mem_addr,
                ph == 0 ? 16'hFFFE : (ph == 1 ? 16'hFFFF : epc));
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual cycles=%0d expected<20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic hold_reset(input int n, input logic [7:0] h, input logic [7:0] l);
        @(negedge clk);
        rst_n = 1'b0;
        vec_hi = h;
        vec_lo = l;
        repeat (n) @(negedge clk);
    endtask

    // Release reset and count the edges until run is seen high.
    task automatic release_and_wait(input string tag, input logic [15:0] exp_pc);
        int n;
        n = 0;
        rst_n = 1'b1;
        chk({tag, " R1 run low in hold"}, run, 1'b0);
        while (!run && n < 10) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R5 edges to run"}, n, 3);
        chk({tag, " R4 pc"}, pc, exp_pc);
    endtask

    initial begin
        // R1: reset state.
        hold_reset(3, 8'h30, 8'h00);
        chk("R1 run", run, 1'b0);
        chk("R1 pc", pc, 16'h0000);
        chk("R1 ccr", ccr, 8'hD0);
        chk("R1 mem_addr", mem_addr, 16'hFFFE);

        // R6: vector example.
        release_and_wait("R6", 16'h3000);
        chk("R6 pc value", pc, 16'h3000);
        repeat (5) @(negedge clk);
        chk("R7 pc held", pc, 16'h3000);
        chk("R7 addr follows pc", mem_addr, 16'h3000);
        chk("R2 ccr in run", ccr, 8'hD0);

        // R8: reset during run, new vector.
        hold_reset(2, 8'hA5, 8'h5C);
        chk("R8 run cleared", run, 1'b0);
        release_and_wait("R8 run-reset", 16'hA55C);

        // R8: reset right after the high byte was requested.
        hold_reset(2, 8'h11, 8'h22);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R3 second addr", mem_addr, 16'hFFFF);
        hold_reset(2, 8'h12, 8'h34);
        release_and_wait("R8 cut at hi", 16'h1234);

        // R8: reset after the high byte was captured.
        hold_reset(2, 8'hDE, 8'hAD);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 no run yet", run, 1'b0);
        hold_reset(2, 8'h00, 8'hFF);
        release_and_wait("R8 cut at lo", 16'h00FF);

        // Boundary: vector at the top of the space.
        hold_reset(2, 8'hFF, 8'hFE);
        release_and_wait("R4 top vector", 16'hFFFE);
        repeat (4) @(negedge clk);
        chk("R7 pc stable at top", pc, 16'hFFFE);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule